// File: doc/BRIEF.md
# Brown-out and Multi-Source Reset Controller

This block sits between the always-on supply monitor and the rest of the chip. It takes an already thresholded low-supply indication, a watchdog time-out, a processor lockup indication, a debug-mode flag and a software request. From these it drives a chip-wide reset, a processor-only reset and a set of sticky cause flags that software reads after it restarts. The supply path is filtered in both directions. A low condition has to stay low for a selectable number of clock cycles before it resets the chip. The supply has to stay good for the same number of cycles before the chip is let out of reset.

The detector enable, the reset enable and the 3-bit threshold level take their values from a configuration word on the first clock after power-on reset. Software can change them afterwards through a small write port. Every asynchronous input passes through a two-stage synchronizer. Only the power-on reset `rst_ni` clears this block's own registers, so the cause flags outlive the chip reset they produce.

Top module: `supply_rst_ctrl`

## Requirements
- R1: On the first clock after `rst_ni` is released, the control word `ctrl_o` loads as follows. Bit 0 (detector enable) takes `cfg_word_i[19]`, bit 1 (reset enable) takes `cfg_word_i[20]`, bits 4:2 (level) take `cfg_word_i[23:21]`, and bits 7:5 (filter select) take 0. Every other configuration bit is ignored, and `sts_o`, `chip_rst_o` and `core_rst_o` are 0.
- R2: Let the filter select be S, and let N = 2^S clock cycles. A low-supply pulse on `lowv_i` that lasts fewer than N cycles causes no chip reset and sets no flag.
- R3: With detector and reset enable set, a `lowv_i` high that is held rises `chip_rst_o` exactly N+2 cycles after `lowv_i` rises. Two of those cycles are synchronizer delay.
- R4: A brown-out chip reset is released exactly N+2 cycles after `lowv_i` falls, provided the input stays low for N cycles. A shorter return to good supply does not release it.
- R5: If reset enable (ctrl bit 1) is 0, or detector enable (ctrl bit 0) is 0, a held low supply produces no chip reset and no brown-out flag.
- R6: `sts_o[0]` is set while a brown-out reset is active. It and the other flags keep their value through a brown-out reset.
- R7: A watchdog pulse on `wdt_tmo_i` sets `sts_o[2]`. It also drives `chip_rst_o` high for 4 cycles, starting 3 cycles after the pulse rises.
- R8: A lockup pulse on `lockup_i` gives the same 4-cycle chip reset and sets `sts_o[1]`, but only while `dbg_mode_i` is low. In debug mode it has no effect.
- R9: A write of data bit 1 = 1 to address 2 drives `core_rst_o` high for 4 cycles, starting on the cycle after the write. `chip_rst_o` stays low and `ctrl_o` and `sts_o` are unchanged. Data bit 1 = 0 does nothing.
- R10: A write to address 1 clears each flag whose data bit (bits 2:0) is 1 and leaves the others alone. A flag whose cause is active in the same cycle stays set.
- R11: A write to address 0 replaces the control word with data bits 7:0, laid out as in R1. Filter select values 0 to 7 give N = 1 to 128 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| cfg_word_i | input | 32 | Configuration word, supplies power-up control defaults |
| lowv_i | input | 1 | Asynchronous low-supply indication, 1 = supply low |
| wdt_tmo_i | input | 1 | Asynchronous watchdog time-out pulse |
| lockup_i | input | 1 | Asynchronous processor lockup indication |
| dbg_mode_i | input | 1 | Asynchronous debug-mode flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 status clear, 2 core reset |
| wr_data_i | input | 8 | Write data |
| chip_rst_o | output | 1 | Chip-wide reset |
| core_rst_o | output | 1 | Processor reset, also high during chip reset |
| ctrl_o | output | 8 | Current control word |
| sts_o | output | 3 | Sticky cause flags: bit 0 brown-out, bit 1 lockup, bit 2 watchdog |

## Verification
The supply input is driven with a pulse one cycle shorter than the filter length and with a held level, which shows whether the filter counts the full window or is off by one. A short return to good supply during reset is followed by a long one, which shows that release is filtered as well as entry. Filter selects 0, 3 and 7 are covered, so any error in the length decode appears at both ends of the range. Lockup is driven once with debug mode set and once with it clear, and status writes use both zero and one data bits, including one during an active brown-out, to separate clearing from a set that wins in the same cycle.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;
  localparam int LVL_W  = 3;
  localparam int SEL_W  = 3;
  localparam int NFLAG  = 3;
  localparam int F_BOD  = 0;
  localparam int F_LOCK = 1;
  localparam int F_WDT  = 2;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STS  = 2'd1,
    A_CORE = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic [SEL_W-1:0] dg_sel;
    logic [LVL_W-1:0] lvl;
    logic             rst_en;
    logic             det_en;
  } bod_ctrl_t;
endpackage

// File: rtl/rst_in_sync.sv
module rst_in_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/bod_filter.sv
module bod_filter #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             raw_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             filt_o
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;
  logic             filt_q;

  // window of 2^sel cycles, sel 0 is a plain register
  assign len_m1 = (CNT_W'(1) << sel_i) - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == len_m1) begin
      filt_q <= raw_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/rst_pulse.sv
module rst_pulse #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (trig_i)        cnt_q <= CW'(LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/supply_rst_ctrl.sv
module supply_rst_ctrl
  import supply_rst_pkg::*;
#(
  parameter int CFG_W        = 32,
  parameter int CFG_EN_BIT   = 19,
  parameter int CFG_RST_BIT  = 20,
  parameter int CFG_LVL_LSB  = 21,
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_LEN    = 4,
  parameter int CORE_BIT     = 1,
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_word_i,
  input  logic              lowv_i,
  input  logic              wdt_tmo_i,
  input  logic              lockup_i,
  input  logic              dbg_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              chip_rst_o,
  output logic              core_rst_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [NFLAG-1:0]  sts_o
);
  localparam int CTRL_W = $bits(bod_ctrl_t);
  localparam int NIN    = 4;

  logic [NIN-1:0] raw_in, syn_in;
  logic           lv_s, wd_s, lk_s, db_s;
  logic           bod_filt, bod_rst;
  logic           wd_ev, lk_ev;
  logic           chip_pulse, core_pulse, core_wr;
  logic           wr_ctrl, wr_sts;
  bod_ctrl_t      ctrl_q;
  logic           cfg_done_q;
  logic [NFLAG-1:0] flags_q, flag_set, flag_clr;
  logic           unused_cfg;

  assign unused_cfg = ^cfg_word_i;

  assign raw_in = {dbg_mode_i, lockup_i, wdt_tmo_i, lowv_i};

  rst_in_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign {db_s, lk_s, wd_s, lv_s} = syn_in;

  bod_filter #(.SEL_W(SEL_W)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl_q.det_en),
    .raw_i (lv_s),
    .sel_i (ctrl_q.dg_sel),
    .filt_o(bod_filt)
  );

  assign bod_rst = bod_filt & ctrl_q.rst_en;
  assign wd_ev   = wd_s;
  assign lk_ev   = lk_s & ~db_s;

  rst_pulse #(.LEN(PULSE_LEN)) u_chip_pulse (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(wd_ev | lk_ev),
    .busy_o(chip_pulse)
  );

  assign wr_ctrl = wr_en_i && (reg_addr_e'(wr_addr_i) == A_CTRL);
  assign wr_sts  = wr_en_i && (reg_addr_e'(wr_addr_i) == A_STS);
  assign core_wr = wr_en_i && (reg_addr_e'(wr_addr_i) == A_CORE) && wr_data_i[CORE_BIT];

  rst_pulse #(.LEN(PULSE_LEN)) u_core_pulse (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(core_wr),
    .busy_o(core_pulse)
  );

  // control word: defaults from config on first clock, then software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      cfg_done_q <= 1'b0;
    end else if (!cfg_done_q) begin
      ctrl_q.det_en <= cfg_word_i[CFG_EN_BIT];
      ctrl_q.rst_en <= cfg_word_i[CFG_RST_BIT];
      ctrl_q.lvl    <= cfg_word_i[CFG_LVL_LSB +: LVL_W];
      ctrl_q.dg_sel <= '0;
      cfg_done_q    <= 1'b1;
    end else if (wr_ctrl) begin
      ctrl_q <= bod_ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end
  end

  // sticky flags, set beats clear
  always_comb begin
    flag_set         = '0;
    flag_set[F_BOD]  = bod_rst;
    flag_set[F_LOCK] = lk_ev;
    flag_set[F_WDT]  = wd_ev;
    flag_clr         = wr_sts ? wr_data_i[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign chip_rst_o = bod_rst | chip_pulse;
  assign core_rst_o = core_pulse | chip_rst_o;
  assign ctrl_o     = DATA_W'(ctrl_q);
  assign sts_o      = flags_q;
endmodule

// File: rtl/supply_rst_ctrl_chk.sv
module supply_rst_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       lv_s_i,
  input logic       wd_s_i,
  input logic       lk_s_i,
  input logic       db_s_i,
  input logic       det_en_i,
  input logic       rst_en_i,
  input logic       bod_filt_i,
  input logic       chip_pulse_i,
  input logic       chip_rst_i,
  input logic       core_rst_i,
  input logic [2:0] sts_i
);
  // R2
  filt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(det_en_i) && !$stable(bod_filt_i)) |-> (bod_filt_i == $past(lv_s_i)));

  // R5
  bod_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_rst_i && !chip_pulse_i) |-> rst_en_i);

  // R7
  wdt_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_s_i |=> (sts_i[2] && chip_rst_i));

  // R8
  lock_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_s_i && !db_s_i) |=> (chip_rst_i && sts_i[1]));

  // R8
  lock_dbg_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_i[1] && !(lk_s_i && !db_s_i)) |=> !sts_i[1]);

  // R9
  core_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd2 && wr_data_i[1]) |=> core_rst_i);

  // R6
  bod_flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[0] && !(wr_en_i && wr_addr_i == 2'd1 && wr_data_i[0])) |=> sts_i[0]);
endmodule

bind supply_rst_ctrl supply_rst_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .lv_s_i      (lv_s),
  .wd_s_i      (wd_s),
  .lk_s_i      (lk_s),
  .db_s_i      (db_s),
  .det_en_i    (ctrl_q.det_en),
  .rst_en_i    (ctrl_q.rst_en),
  .bod_filt_i  (bod_filt),
  .chip_pulse_i(chip_pulse),
  .chip_rst_i  (chip_rst_o),
  .core_rst_i  (core_rst_o),
  .sts_i       (sts_o)
);

// File: tb/supply_rst_ctrl_bench.sv
`timescale 1ns/1ps
module supply_rst_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = 32'h01B8_F00F;
  logic        lowv = 0, wdt = 0, lock = 0, dbg = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic        chip_rst, core_rst;
  logic [7:0]  ctrl;
  logic [2:0]  sts;

  int    total = 0, bad = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  supply_rst_ctrl u_supply_rst_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_word_i(cfg),
    .lowv_i(lowv), .wdt_tmo_i(wdt), .lockup_i(lock), .dbg_mode_i(dbg),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .chip_rst_o(chip_rst), .core_rst_o(core_rst), .ctrl_o(ctrl), .sts_o(sts)
  );

  // behavioural reference
  int m_en, m_rsten, m_lvl, m_sel, m_loaded, m_filt, m_run, m_pc, m_cc;
  bit m_fl[3];
  bit q_lv[$], q_wd[$], q_lk[$], q_db[$];

  always @(posedge clk) begin
    int s_lv, s_wd, s_lk, s_db, bod, wd_ev, lk_ev;
    if (!rst_n) begin
      m_en = 0; m_rsten = 0; m_lvl = 0; m_sel = 0; m_loaded = 0;
      m_filt = 0; m_run = 0; m_pc = 0; m_cc = 0;
      foreach (m_fl[i]) m_fl[i] = 0;
      q_lv = '{0, 0}; q_wd = '{0, 0}; q_lk = '{0, 0}; q_db = '{0, 0};
    end else begin
      s_lv = q_lv[0]; s_wd = q_wd[0]; s_lk = q_lk[0]; s_db = q_db[0];
      bod = (m_filt != 0) && (m_rsten != 0);
      if (m_en == 0) begin m_filt = 0; m_run = 0; end
      else if (s_lv == m_filt) m_run = 0;
      else if (m_run == (1 << m_sel) - 1) begin m_filt = s_lv; m_run = 0; end
      else m_run++;
      wd_ev = s_wd;
      lk_ev = s_lk && !s_db;
      if (wd_ev || lk_ev) m_pc = 4; else if (m_pc > 0) m_pc--;
      if (wr_en && wr_addr == 2 && wr_data[1]) m_cc = 4; else if (m_cc > 0) m_cc--;
      if (wr_en && wr_addr == 1) for (int i = 0; i < 3; i++) if (wr_data[i]) m_fl[i] = 0;
      if (bod) m_fl[0] = 1;
      if (lk_ev) m_fl[1] = 1;
      if (wd_ev) m_fl[2] = 1;
      if (m_loaded == 0) begin
        m_en = cfg[19]; m_rsten = cfg[20]; m_lvl = cfg[23:21]; m_sel = 0; m_loaded = 1;
      end else if (wr_en && wr_addr == 0) begin
        m_en = wr_data[0]; m_rsten = wr_data[1]; m_lvl = wr_data[4:2]; m_sel = wr_data[7:5];
      end
      q_lv.push_back(lowv); void'(q_lv.pop_front());
      q_wd.push_back(wdt);  void'(q_wd.pop_front());
      q_lk.push_back(lock); void'(q_lk.pop_front());
      q_db.push_back(dbg);  void'(q_db.pop_front());
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic e_chip;
    if (rst_n) begin
      e_chip = ((m_filt != 0) && (m_rsten != 0)) || (m_pc > 0);
      check({cur_req, " chip"}, 32'(chip_rst), 32'(e_chip));
      check({cur_req, " core"}, 32'(core_rst), 32'(e_chip || (m_cc > 0)));
      check({cur_req, " ctrl"}, 32'(ctrl), 32'((m_sel << 5) | (m_lvl << 2) | (m_rsten << 1) | m_en));
      check({cur_req, " sts"}, 32'(sts), 32'({m_fl[2], m_fl[1], m_fl[0]}));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    step(4); rst_n = 1; step(3);
    check("R1 ctrl", 32'(ctrl), 32'h17);
    check("R1 sts", 32'(sts), 0);
    check("R1 chip", 32'(chip_rst), 0);

    cur_req = "R11"; wr(0, 8'h77); step(1);
    check("R11 ctrl", 32'(ctrl), 32'h77);

    cur_req = "R2"; lowv = 1; step(7); lowv = 0; step(15);
    check("R2 chip", 32'(chip_rst), 0);
    check("R2 sts", 32'(sts), 0);

    cur_req = "R3"; lowv = 1; step(9);
    check("R3 chip early", 32'(chip_rst), 0);
    step(1);
    check("R3 chip", 32'(chip_rst), 1);

    cur_req = "R10"; wr(1, 8'h01);
    check("R10 set wins", 32'(sts[0]), 1);

    cur_req = "R4"; lowv = 0; step(5); lowv = 1; step(4);
    check("R4 short recovery", 32'(chip_rst), 1);
    lowv = 0; step(9);
    check("R4 held early", 32'(chip_rst), 1);
    step(1);
    check("R4 release", 32'(chip_rst), 0);
    check("R6 bod flag", 32'(sts[0]), 1);

    cur_req = "R10"; wr(1, 8'h00);
    check("R10 zero keeps", 32'(sts), 1);
    wr(1, 8'h01);
    check("R10 clear", 32'(sts), 0);

    cur_req = "R5"; wr(0, 8'h75); lowv = 1; step(20);
    check("R5 rst_en off", 32'(chip_rst), 0);
    check("R5 no flag", 32'(sts), 0);
    lowv = 0; step(20);
    wr(0, 8'h76); lowv = 1; step(20);
    check("R5 det off", 32'(chip_rst), 0);
    check("R5 det off flag", 32'(sts), 0);
    lowv = 0; step(5); wr(0, 8'h77); step(3);

    cur_req = "R7"; wdt = 1; step(1); wdt = 0; step(1);
    check("R7 before", 32'(chip_rst), 0);
    step(1);
    check("R7 start", 32'(chip_rst), 1);
    step(3);
    check("R7 last", 32'(chip_rst), 1);
    step(1);
    check("R7 end", 32'(chip_rst), 0);
    check("R7 flag", 32'(sts[2]), 1);

    cur_req = "R8"; dbg = 1; step(3); lock = 1; step(1); lock = 0; step(10);
    check("R8 masked", 32'(chip_rst), 0);
    check("R8 masked flag", 32'(sts[1]), 0);
    dbg = 0; step(3); lock = 1; step(1); lock = 0; step(2);
    check("R8 reset", 32'(chip_rst), 1);
    check("R8 flag", 32'(sts[1]), 1);
    step(10);

    cur_req = "R9"; wr(2, 8'h02);
    check("R9 core", 32'(core_rst), 1);
    check("R9 chip", 32'(chip_rst), 0);
    step(3);
    check("R9 core last", 32'(core_rst), 1);
    step(1);
    check("R9 core end", 32'(core_rst), 0);
    wr(2, 8'h01); step(4);
    check("R9 bit0 ignored", 32'(core_rst), 0);
    check("R9 ctrl kept", 32'(ctrl), 32'h77);
    check("R9 sts kept", 32'(sts), 32'h6);

    cur_req = "R6"; lowv = 1; step(12);
    check("R6 chip", 32'(chip_rst), 1);
    check("R6 flags survive", 32'(sts), 32'h7);
    lowv = 0; step(12);
    check("R6 after release", 32'(sts), 32'h7);

    cur_req = "R11"; wr(0, 8'h17); lowv = 1; step(1); lowv = 0; step(1);
    check("R11 sel0 early", 32'(chip_rst), 0);
    step(1);
    check("R11 sel0 rise", 32'(chip_rst), 1);
    step(1);
    check("R11 sel0 release", 32'(chip_rst), 0);
    wr(0, 8'hF7); lowv = 1; step(129);
    check("R11 sel7 early", 32'(chip_rst), 0);
    step(1);
    check("R11 sel7 rise", 32'(chip_rst), 1);
    lowv = 0; step(140);
    check("R11 sel7 release", 32'(chip_rst), 0);

    finish_run();
  end
endmodule